// File: doc/BRIEF.md
# Four-Phase Accumulator CPU Sequencer

This block is the control unit of a small accumulator processor with separate instruction and data memories. It owns the program counter (PC), the stack pointer (SP) and the instruction register (IR). It takes every instruction through four phases in a fixed order. Fetch (phase 0) latches the instruction word addressed by the PC. Decode (phase 1) lets the opcode settle through the decoder. Execute (phase 2) drives the datapath command, the register-file controls and, when the instruction needs it, a data-memory read address. WriteBack (phase 3) drives any data-memory write and ends with the PC and SP update. The transitions are Fetch→Decode, Decode→Execute, Execute→WriteBack and WriteBack→Fetch, one per clock. There are no other transitions.

An instruction word holds two ignored upper bits, then a 6-bit opcode, then a `DATA_W`-bit operand in the low bits. Data-memory reads are combinational in the cycle the address is issued, and writes take effect at the clock edge that ends WriteBack. The arithmetic datapath, the register file and the memories sit outside this block. The sequencer only steers them, and it reads back the four condition flags and the accumulator value.

Top module: `acc_cpu_sequencer`

## Requirements
- R1: While reset is held and right after it, `phase` is 0 (Fetch), `imem_addr` is 0, SP is 0 (so the first PUSH writes address 0), and `dpu_en`, `dmem_rd_en`, `dmem_we` and `rf_we` are low.
- R2: `phase` steps 0→1→2→3→0, advancing once per clock with no stall.
- R3: The IR takes the instruction word at the clock edge that ends Fetch, and later changes on `imem_data` do not affect that instruction. In Fetch and Decode, `dpu_en`, `dmem_rd_en`, `rf_we` and `dmem_we` are all low.
- R4: `dmem_rd_en` rises only in Execute. The read address is the operand for opcodes 0x01, 0x04, 0x1F and 0x22, the accumulator for 0x25, and SP-1 for 0x3D (POP). No other opcode reads.
- R5: `dmem_we` rises only in WriteBack, with `dmem_wdata` equal to the accumulator. The write address is the operand for 0x20 (store) and SP for 0x3C (PUSH). No other opcode writes.
- R6: The PC changes only at the edge that ends WriteBack. By default the next PC is PC+1, modulo 2^PC_W.
- R7: Opcode 0x13 loads the operand into the PC. Opcodes 0x14, 0x15, 0x16 and 0x18 load the operand if Z, OV, C or EQ respectively is set, and otherwise go to PC+1.
- R8: Opcode 0x17 sets the PC to PC+operand, modulo 2^PC_W. Opcode 0x1D sets the PC to the accumulator value.
- R9: Opcode 0x3F (halt) leaves the PC unchanged, so the same instruction is fetched again.
- R10: PUSH (0x3C) increments SP after its write, and POP (0x3D) decrements SP after its read. Both wrap modulo 2^DATA_W.
- R11: For opcodes 0x00–0x07, `dpu_en` is high in Execute and `dpu_op` is 1 (add) for 0x00, 0x01, 0x02 and 0x06, or 2 (subtract) for 0x03, 0x04, 0x05 and 0x07. `dpu_src` is 2 (register) for 0x00 and 0x03, 0 (memory) for 0x01 and 0x04, 1 (control data) for 0x02 and 0x05, and 3 (constant one) for 0x06 and 0x07. `dpu_data` equals the operand for 0x02 and 0x05, and `rf_rsel` equals operand[2:0] for 0x00 and 0x03.
- R12: In Execute, `dpu_clr` is 3'b001 for 0x19, 3'b010 for 0x1A and 3'b100 for 0x1B. It is 3'b000 for every other opcode.
- R13: `rf_we` rises only in Execute, and only for three opcodes. For 0x21, `rf_wsel` is 1 and `rf_in` is 1. For 0x22, `rf_wsel` is 1, `rf_in` is 3 and the read address is the operand. For 0x24, `rf_wsel` equals operand[7:0] and `rf_in` is 2.
- R14: The two upper instruction bits have no effect. Opcodes 0x26–0x3B and 0x3E raise no strobe (`dpu_en`, `dmem_rd_en`, `dmem_we`, `rf_we`) and advance the PC to PC+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | PC_W | Instruction memory address (the PC) |
| imem_data | input | DATA_W+8 | Instruction word: ignored[1:0], opcode[5:0], operand |
| phase | output | 2 | Current phase: 0 Fetch, 1 Decode, 2 Execute, 3 WriteBack |
| flag_z | input | 1 | Zero flag |
| flag_ov | input | 1 | Signed overflow flag |
| flag_c | input | 1 | Carry flag |
| flag_eq | input | 1 | Accumulator-equals-operand flag |
| acc_value | input | DATA_W | Accumulator value |
| dmem_rd_en | output | 1 | Data memory read strobe |
| dmem_raddr | output | DATA_W | Data memory read address |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_waddr | output | DATA_W | Data memory write address |
| dmem_wdata | output | DATA_W | Data memory write data |
| dpu_en | output | 1 | Datapath operation enable |
| dpu_op | output | 4 | Datapath operation code |
| dpu_src | output | 2 | Datapath second-operand source select |
| dpu_data | output | DATA_W | Control data to the datapath (operand, or PC for save-PC) |
| dpu_clr | output | 3 | Flag clear mask |
| rf_we | output | 1 | Register file write strobe |
| rf_wsel | output | RF_N | One-hot register write select |
| rf_in | output | 2 | Register file input select |
| rf_rsel | output | $clog2(RF_N) | Register read select |

## Verification
All 64 opcodes are swept under each of the four values of the ignored upper bits. The operand, accumulator and flag values vary from one instruction to the next, so a decoder that looks at the upper bits, or that confuses two neighbouring opcodes, shows up as a wrong strobe, address or PC. The four conditional jumps are then run against all 16 flag patterns, which separates a branch that tests the wrong flag from one that tests the right flag. Relative jumps with large operands check the PC wraparound, and a POP from an SP of zero checks the SP wraparound. Two consecutive halts, followed by a no-op, show that the PC freezes and that the sequencer still cycles through its phases.

// File: rtl/acc_cpu_seq_pkg.sv
package acc_cpu_seq_pkg;

    typedef enum logic [1:0] {
        PH_FETCH  = 2'd0,
        PH_DECODE = 2'd1,
        PH_EXEC   = 2'd2,
        PH_WB     = 2'd3
    } phase_e;

    typedef enum logic [3:0] {
        ALU_PASS_ACC = 4'd0,
        ALU_ADD      = 4'd1,
        ALU_SUB      = 4'd2,
        ALU_AND      = 4'd3,
        ALU_OR       = 4'd4,
        ALU_XOR      = 4'd5,
        ALU_INV      = 4'd6,
        ALU_NEG      = 4'd7,
        ALU_LSR      = 4'd8,
        ALU_LSL      = 4'd9,
        ALU_ASR      = 4'd10,
        ALU_ASL      = 4'd11,
        ALU_RRC      = 4'd12,
        ALU_RLC      = 4'd13,
        ALU_PASS_SRC = 4'd14,
        ALU_ZERO     = 4'd15
    } alu_e;

    typedef enum logic [1:0] {
        SRC_MEM = 2'd0,
        SRC_CTL = 2'd1,
        SRC_REG = 2'd2,
        SRC_ONE = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        RIN_ZERO = 2'd0,
        RIN_CTL  = 2'd1,
        RIN_ALU  = 2'd2,
        RIN_MEM  = 2'd3
    } rin_e;

    typedef enum logic [1:0] {
        RA_OPERAND = 2'd0,
        RA_ACC     = 2'd1,
        RA_SPM1    = 2'd2
    } raddr_e;

    typedef enum logic [2:0] {
        PCS_STEP = 3'd0,
        PCS_ABS  = 3'd1,
        PCS_COND = 3'd2,
        PCS_REL  = 3'd3,
        PCS_ACC  = 3'd4,
        PCS_HOLD = 3'd5
    } pcsel_e;

    typedef enum logic [1:0] {
        CND_Z  = 2'd0,
        CND_OV = 2'd1,
        CND_C  = 2'd2,
        CND_EQ = 2'd3
    } cond_e;

    // Opcode values (6-bit field of the instruction word)
    localparam logic [5:0] OPC_ADD_REG  = 6'h00;
    localparam logic [5:0] OPC_ADD_MEM  = 6'h01;
    localparam logic [5:0] OPC_ADD_IMM  = 6'h02;
    localparam logic [5:0] OPC_SUB_REG  = 6'h03;
    localparam logic [5:0] OPC_SUB_MEM  = 6'h04;
    localparam logic [5:0] OPC_SUB_IMM  = 6'h05;
    localparam logic [5:0] OPC_INC      = 6'h06;
    localparam logic [5:0] OPC_DEC      = 6'h07;
    localparam logic [5:0] OPC_ASR      = 6'h08;
    localparam logic [5:0] OPC_ASL      = 6'h09;
    localparam logic [5:0] OPC_LSR      = 6'h0A;
    localparam logic [5:0] OPC_LSL      = 6'h0B;
    localparam logic [5:0] OPC_RRC      = 6'h0C;
    localparam logic [5:0] OPC_RLC      = 6'h0D;
    localparam logic [5:0] OPC_AND_REG  = 6'h0E;
    localparam logic [5:0] OPC_OR_REG   = 6'h0F;
    localparam logic [5:0] OPC_XOR_REG  = 6'h10;
    localparam logic [5:0] OPC_INV      = 6'h11;
    localparam logic [5:0] OPC_NEG      = 6'h12;
    localparam logic [5:0] OPC_JMP      = 6'h13;
    localparam logic [5:0] OPC_JZ       = 6'h14;
    localparam logic [5:0] OPC_JOV      = 6'h15;
    localparam logic [5:0] OPC_JC       = 6'h16;
    localparam logic [5:0] OPC_JREL     = 6'h17;
    localparam logic [5:0] OPC_JEQ      = 6'h18;
    localparam logic [5:0] OPC_CLR_Z    = 6'h19;
    localparam logic [5:0] OPC_CLR_OV   = 6'h1A;
    localparam logic [5:0] OPC_CLR_C    = 6'h1B;
    localparam logic [5:0] OPC_CLR_ACC  = 6'h1C;
    localparam logic [5:0] OPC_PC_ACC   = 6'h1D;
    localparam logic [5:0] OPC_SAVE_PC  = 6'h1E;
    localparam logic [5:0] OPC_LD_MEM   = 6'h1F;
    localparam logic [5:0] OPC_ST_MEM   = 6'h20;
    localparam logic [5:0] OPC_R0_IMM   = 6'h21;
    localparam logic [5:0] OPC_R0_MEM   = 6'h22;
    localparam logic [5:0] OPC_LD_REG   = 6'h23;
    localparam logic [5:0] OPC_ST_REG   = 6'h24;
    localparam logic [5:0] OPC_LD_IND   = 6'h25;
    localparam logic [5:0] OPC_PUSH     = 6'h3C;
    localparam logic [5:0] OPC_POP      = 6'h3D;
    localparam logic [5:0] OPC_NOP      = 6'h3E;
    localparam logic [5:0] OPC_HALT     = 6'h3F;

    typedef struct packed {
        logic        dpu;
        alu_e        alu;
        src_e        src;
        logic        pc_data;
        logic [2:0]  clr;
        logic        rd;
        raddr_e      ra;
        logic        wr;
        logic        wr_sp;
        logic        rf_we;
        logic        rf_r0;
        rin_e        rin;
        pcsel_e      pcs;
        cond_e       cnd;
        logic        sp_inc;
        logic        sp_dec;
    } ctl_t;

endpackage

// File: rtl/acc_cpu_phase_fsm.sv
module acc_cpu_phase_fsm
    import acc_cpu_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_e phase,
    output logic   in_fetch,
    output logic   in_exec,
    output logic   in_wb
);

    phase_e phase_q;
    phase_e phase_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_FETCH;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Transitions and phase strobes
    always_comb begin
        phase_d  = PH_FETCH;
        in_fetch = 1'b0;
        in_exec  = 1'b0;
        in_wb    = 1'b0;
        unique case (phase_q)
            PH_FETCH: begin
                in_fetch = 1'b1;
                phase_d  = PH_DECODE;
            end
            PH_DECODE: begin
                phase_d  = PH_EXEC;
            end
            PH_EXEC: begin
                in_exec  = 1'b1;
                phase_d  = PH_WB;
            end
            PH_WB: begin
                in_wb    = 1'b1;
                phase_d  = PH_FETCH;
            end
        endcase
    end

    assign phase = phase_q;

endmodule

// File: rtl/acc_cpu_decoder.sv
module acc_cpu_decoder
    import acc_cpu_seq_pkg::*;
(
    input  logic [5:0] opc,
    output ctl_t       ctl
);

    always_comb begin
        ctl         = '0;
        ctl.alu     = ALU_PASS_ACC;
        ctl.src     = SRC_MEM;
        ctl.ra      = RA_OPERAND;
        ctl.rin     = RIN_ZERO;
        ctl.pcs     = PCS_STEP;
        ctl.cnd     = CND_Z;
        case (opc)
            OPC_ADD_REG: begin ctl.dpu = 1'b1; ctl.alu = ALU_ADD; ctl.src = SRC_REG; end
            OPC_ADD_MEM: begin ctl.dpu = 1'b1; ctl.alu = ALU_ADD; ctl.src = SRC_MEM; ctl.rd = 1'b1; end
            OPC_ADD_IMM: begin ctl.dpu = 1'b1; ctl.alu = ALU_ADD; ctl.src = SRC_CTL; end
            OPC_SUB_REG: begin ctl.dpu = 1'b1; ctl.alu = ALU_SUB; ctl.src = SRC_REG; end
            OPC_SUB_MEM: begin ctl.dpu = 1'b1; ctl.alu = ALU_SUB; ctl.src = SRC_MEM; ctl.rd = 1'b1; end
            OPC_SUB_IMM: begin ctl.dpu = 1'b1; ctl.alu = ALU_SUB; ctl.src = SRC_CTL; end
            OPC_INC:     begin ctl.dpu = 1'b1; ctl.alu = ALU_ADD; ctl.src = SRC_ONE; end
            OPC_DEC:     begin ctl.dpu = 1'b1; ctl.alu = ALU_SUB; ctl.src = SRC_ONE; end
            OPC_ASR:     begin ctl.dpu = 1'b1; ctl.alu = ALU_ASR; end
            OPC_ASL:     begin ctl.dpu = 1'b1; ctl.alu = ALU_ASL; end
            OPC_LSR:     begin ctl.dpu = 1'b1; ctl.alu = ALU_LSR; end
            OPC_LSL:     begin ctl.dpu = 1'b1; ctl.alu = ALU_LSL; end
            OPC_RRC:     begin ctl.dpu = 1'b1; ctl.alu = ALU_RRC; end
            OPC_RLC:     begin ctl.dpu = 1'b1; ctl.alu = ALU_RLC; end
            OPC_AND_REG: begin ctl.dpu = 1'b1; ctl.alu = ALU_AND; ctl.src = SRC_REG; end
            OPC_OR_REG:  begin ctl.dpu = 1'b1; ctl.alu = ALU_OR;  ctl.src = SRC_REG; end
            OPC_XOR_REG: begin ctl.dpu = 1'b1; ctl.alu = ALU_XOR; ctl.src = SRC_REG; end
            OPC_INV:     begin ctl.dpu = 1'b1; ctl.alu = ALU_INV; end
            OPC_NEG:     begin ctl.dpu = 1'b1; ctl.alu = ALU_NEG; end
            OPC_JMP:     begin ctl.pcs = PCS_ABS; end
            OPC_JZ:      begin ctl.pcs = PCS_COND; ctl.cnd = CND_Z;  end
            OPC_JOV:     begin ctl.pcs = PCS_COND; ctl.cnd = CND_OV; end
            OPC_JC:      begin ctl.pcs = PCS_COND; ctl.cnd = CND_C;  end
            OPC_JREL:    begin ctl.pcs = PCS_REL; end
            OPC_JEQ:     begin ctl.pcs = PCS_COND; ctl.cnd = CND_EQ; end
            OPC_CLR_Z:   begin ctl.dpu = 1'b1; ctl.clr = 3'b001; end
            OPC_CLR_OV:  begin ctl.dpu = 1'b1; ctl.clr = 3'b010; end
            OPC_CLR_C:   begin ctl.dpu = 1'b1; ctl.clr = 3'b100; end
            OPC_CLR_ACC: begin ctl.dpu = 1'b1; ctl.alu = ALU_ZERO; end
            OPC_PC_ACC:  begin ctl.pcs = PCS_ACC; end
            OPC_SAVE_PC: begin
                ctl.dpu     = 1'b1;
                ctl.alu     = ALU_PASS_SRC;
                ctl.src     = SRC_CTL;
                ctl.pc_data = 1'b1;
            end
            OPC_LD_MEM:  begin ctl.dpu = 1'b1; ctl.alu = ALU_PASS_SRC; ctl.src = SRC_MEM; ctl.rd = 1'b1; end
            OPC_ST_MEM:  begin ctl.wr = 1'b1; end
            OPC_R0_IMM:  begin ctl.rf_we = 1'b1; ctl.rf_r0 = 1'b1; ctl.rin = RIN_CTL; end
            OPC_R0_MEM:  begin ctl.rf_we = 1'b1; ctl.rf_r0 = 1'b1; ctl.rin = RIN_MEM; ctl.rd = 1'b1; end
            OPC_LD_REG:  begin ctl.dpu = 1'b1; ctl.alu = ALU_PASS_SRC; ctl.src = SRC_REG; end
            OPC_ST_REG:  begin ctl.dpu = 1'b1; ctl.rf_we = 1'b1; ctl.rin = RIN_ALU; end
            OPC_LD_IND:  begin
                ctl.dpu = 1'b1;
                ctl.alu = ALU_PASS_SRC;
                ctl.src = SRC_MEM;
                ctl.rd  = 1'b1;
                ctl.ra  = RA_ACC;
            end
            OPC_PUSH:    begin ctl.wr = 1'b1; ctl.wr_sp = 1'b1; ctl.sp_inc = 1'b1; end
            OPC_POP:     begin
                ctl.dpu    = 1'b1;
                ctl.alu    = ALU_PASS_SRC;
                ctl.src    = SRC_MEM;
                ctl.rd     = 1'b1;
                ctl.ra     = RA_SPM1;
                ctl.sp_dec = 1'b1;
            end
            OPC_HALT:    begin ctl.pcs = PCS_HOLD; end
            default:     begin end // NOP and undefined codes
        endcase
    end

endmodule

// File: rtl/acc_cpu_pc_sp.sv
module acc_cpu_pc_sp
    import acc_cpu_seq_pkg::*;
#(
    parameter int PC_W   = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_en,
    input  pcsel_e            pcs,
    input  cond_e             cnd,
    input  logic              sp_inc,
    input  logic              sp_dec,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] acc,
    input  logic [3:0]        flags,   // {eq, c, ov, z}
    output logic [PC_W-1:0]   pc,
    output logic [DATA_W-1:0] sp
);

    logic [PC_W-1:0]   pc_q, pc_d, pc_step;
    logic [DATA_W-1:0] sp_q, sp_d;
    logic              taken;

    assign pc_step = pc_q + PC_W'(1);

    always_comb begin
        unique case (cnd)
            CND_Z:  taken = flags[0];
            CND_OV: taken = flags[1];
            CND_C:  taken = flags[2];
            CND_EQ: taken = flags[3];
        endcase
    end

    always_comb begin
        pc_d = pc_step;
        case (pcs)
            PCS_ABS:  pc_d = PC_W'(operand);
            PCS_COND: pc_d = taken ? PC_W'(operand) : pc_step;
            PCS_REL:  pc_d = pc_q + PC_W'(operand);
            PCS_ACC:  pc_d = PC_W'(acc);
            PCS_HOLD: pc_d = pc_q;
            default:  pc_d = pc_step;
        endcase
    end

    always_comb begin
        sp_d = sp_q;
        if (sp_inc) begin
            sp_d = sp_q + DATA_W'(1);
        end else if (sp_dec) begin
            sp_d = sp_q - DATA_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
            sp_q <= '0;
        end else if (wb_en) begin
            pc_q <= pc_d;
            sp_q <= sp_d;
        end
    end

    assign pc = pc_q;
    assign sp = sp_q;

endmodule

// File: rtl/acc_cpu_sequencer.sv
module acc_cpu_sequencer
    import acc_cpu_seq_pkg::*;
#(
    parameter  int DATA_W  = 8,
    parameter  int PC_W    = 8,
    parameter  int RF_N    = 8,
    localparam int INSTR_W = DATA_W + 8,
    localparam int RSEL_W  = $clog2(RF_N)
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [PC_W-1:0]    imem_addr,
    input  logic [INSTR_W-1:0] imem_data,
    output logic [1:0]         phase,
    input  logic               flag_z,
    input  logic               flag_ov,
    input  logic               flag_c,
    input  logic               flag_eq,
    input  logic [DATA_W-1:0]  acc_value,
    output logic               dmem_rd_en,
    output logic [DATA_W-1:0]  dmem_raddr,
    output logic               dmem_we,
    output logic [DATA_W-1:0]  dmem_waddr,
    output logic [DATA_W-1:0]  dmem_wdata,
    output logic               dpu_en,
    output logic [3:0]         dpu_op,
    output logic [1:0]         dpu_src,
    output logic [DATA_W-1:0]  dpu_data,
    output logic [2:0]         dpu_clr,
    output logic               rf_we,
    output logic [RF_N-1:0]    rf_wsel,
    output logic [1:0]         rf_in,
    output logic [RSEL_W-1:0]  rf_rsel
);

    localparam int IR_W = DATA_W + 6;

    phase_e            phase_q;
    logic              in_fetch, in_exec, in_wb;
    logic [IR_W-1:0]   ir_q;
    logic [1:0]        rsv_unused;
    logic [5:0]        opc;
    logic [DATA_W-1:0] operand;
    ctl_t              ctl;
    logic [PC_W-1:0]   pc;
    logic [DATA_W-1:0] sp;

    acc_cpu_phase_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase_q),
        .in_fetch (in_fetch),
        .in_exec  (in_exec),
        .in_wb    (in_wb)
    );

    // Instruction register; the two top bits are not kept
    assign rsv_unused = imem_data[INSTR_W-1 -: 2];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q <= '0;
        end else if (in_fetch) begin
            ir_q <= imem_data[IR_W-1:0];
        end
    end

    assign opc     = ir_q[IR_W-1 -: 6];
    assign operand = ir_q[DATA_W-1:0];

    acc_cpu_decoder u_dec (
        .opc (opc),
        .ctl (ctl)
    );

    acc_cpu_pc_sp #(
        .PC_W   (PC_W),
        .DATA_W (DATA_W)
    ) u_pcsp (
        .clk     (clk),
        .rst_n   (rst_n),
        .wb_en   (in_wb),
        .pcs     (ctl.pcs),
        .cnd     (ctl.cnd),
        .sp_inc  (ctl.sp_inc),
        .sp_dec  (ctl.sp_dec),
        .operand (operand),
        .acc     (acc_value),
        .flags   ({flag_eq, flag_c, flag_ov, flag_z}),
        .pc      (pc),
        .sp      (sp)
    );

    assign imem_addr = pc;
    assign phase     = phase_q;

    // Phase-gated outputs
    always_comb begin
        dpu_en     = in_exec & ctl.dpu;
        dpu_op     = in_exec ? ctl.alu : ALU_PASS_ACC;
        dpu_src    = ctl.src;
        dpu_data   = ctl.pc_data ? DATA_W'(pc) : operand;
        dpu_clr    = in_exec ? ctl.clr : 3'b000;

        dmem_rd_en = in_exec & ctl.rd;
        unique case (ctl.ra)
            RA_ACC:  dmem_raddr = acc_value;
            RA_SPM1: dmem_raddr = sp - DATA_W'(1);
            default: dmem_raddr = operand;
        endcase

        dmem_we    = in_wb & ctl.wr;
        dmem_waddr = ctl.wr_sp ? sp : operand;
        dmem_wdata = acc_value;

        rf_we      = in_exec & ctl.rf_we;
        rf_wsel    = ctl.rf_r0 ? RF_N'(1) : operand[RF_N-1:0];
        rf_in      = ctl.rin;
        rf_rsel    = operand[RSEL_W-1:0];
    end

endmodule

// File: rtl/acc_cpu_seq_checker.sv
module acc_cpu_seq_checker #(
    parameter int PC_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      phase,
    input logic            dpu_en,
    input logic            dmem_rd_en,
    input logic            dmem_we,
    input logic            rf_we,
    input logic [PC_W-1:0] imem_addr
);

    // R2: phase order
    a_r2_fetch_then_decode: assert property (@(posedge clk) disable iff (!rst_n)
        phase == 2'd0 |=> phase == 2'd1);
    a_r2_decode_then_exec: assert property (@(posedge clk) disable iff (!rst_n)
        phase == 2'd1 |=> phase == 2'd2);
    a_r2_exec_then_wb: assert property (@(posedge clk) disable iff (!rst_n)
        phase == 2'd2 |=> phase == 2'd3);
    a_r2_wb_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        phase == 2'd3 |=> phase == 2'd0);

    // R3: no activity in Fetch or Decode
    a_r3_quiet_early: assert property (@(posedge clk) disable iff (!rst_n)
        phase < 2'd2 |-> !(dpu_en || dmem_rd_en || rf_we || dmem_we));

    // R4: reads only in Execute
    a_r4_read_in_exec: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_rd_en |-> phase == 2'd2);

    // R13: register writes only in Execute
    a_r13_rf_in_exec: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> phase == 2'd2);

    // R5: writes only in WriteBack
    a_r5_write_in_wb: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> phase == 2'd3);

    // R6: PC only moves out of WriteBack
    a_r6_pc_stable: assert property (@(posedge clk) disable iff (!rst_n)
        phase != 2'd3 |=> $stable(imem_addr));

endmodule

bind acc_cpu_sequencer acc_cpu_seq_checker #(.PC_W(PC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .dpu_en     (dpu_en),
    .dmem_rd_en (dmem_rd_en),
    .dmem_we    (dmem_we),
    .rf_we      (rf_we),
    .imem_addr  (imem_addr)
);

// File: tb/acc_cpu_sequencer_tb.sv
module acc_cpu_sequencer_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  imem_addr;
    logic [15:0] imem_data;
    logic [1:0]  phase;
    logic        flag_z, flag_ov, flag_c, flag_eq;
    logic [7:0]  acc_value;
    logic        dmem_rd_en, dmem_we, dpu_en, rf_we;
    logic [7:0]  dmem_raddr, dmem_waddr, dmem_wdata, dpu_data, rf_wsel;
    logic [3:0]  dpu_op;
    logic [1:0]  dpu_src, rf_in;
    logic [2:0]  dpu_clr, rf_rsel;

    always #10 clk = ~clk; // 50 MHz

    acc_cpu_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
        .phase(phase), .flag_z(flag_z), .flag_ov(flag_ov), .flag_c(flag_c),
        .flag_eq(flag_eq), .acc_value(acc_value), .dmem_rd_en(dmem_rd_en),
        .dmem_raddr(dmem_raddr), .dmem_we(dmem_we), .dmem_waddr(dmem_waddr),
        .dmem_wdata(dmem_wdata), .dpu_en(dpu_en), .dpu_op(dpu_op),
        .dpu_src(dpu_src), .dpu_data(dpu_data), .dpu_clr(dpu_clr),
        .rf_we(rf_we), .rf_wsel(rf_wsel), .rf_in(rf_in), .rf_rsel(rf_rsel)
    );

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    logic [7:0] m_pc = 8'd0;
    logic [7:0] m_sp = 8'd0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Starts and ends at a falling edge inside Fetch
    task automatic run_instr(input logic [1:0] rsv, input logic [5:0] opc,
                             input logic [7:0] opd, input logic [3:0] flg,
                             input logic [7:0] acc);
        logic [7:0] e_pc, e_sp, e_ra, e_wa, e_sel;
        bit         e_rd, e_wr, e_rf, undef;
        logic [2:0] e_clr;
        logic [1:0] e_in;
        string      pc_tag;
        e_pc = m_pc + 8'd1; e_sp = m_sp; pc_tag = "R6";
        e_rd = 0; e_ra = opd; e_wr = 0; e_wa = opd; e_rf = 0; e_sel = 0; e_in = 0; e_clr = 0;
        undef = (opc >= 6'h26 && opc <= 6'h3B) || opc == 6'h3E;
        case (opc)
            6'h13: begin e_pc = opd; pc_tag = "R7"; end
            6'h14: begin e_pc = flg[0] ? opd : m_pc + 8'd1; pc_tag = "R7 z"; end
            6'h15: begin e_pc = flg[1] ? opd : m_pc + 8'd1; pc_tag = "R7 ov"; end
            6'h16: begin e_pc = flg[2] ? opd : m_pc + 8'd1; pc_tag = "R7 c"; end
            6'h18: begin e_pc = flg[3] ? opd : m_pc + 8'd1; pc_tag = "R7 eq"; end
            6'h17: begin e_pc = m_pc + opd; pc_tag = "R8 rel"; end
            6'h1D: begin e_pc = acc; pc_tag = "R8 acc"; end
            6'h3F: begin e_pc = m_pc; pc_tag = "R9"; end
            6'h01, 6'h04, 6'h1F: e_rd = 1;
            6'h25: begin e_rd = 1; e_ra = acc; end
            6'h3D: begin e_rd = 1; e_ra = m_sp - 8'd1; e_sp = m_sp - 8'd1; end
            6'h20: e_wr = 1;
            6'h3C: begin e_wr = 1; e_wa = m_sp; e_sp = m_sp + 8'd1; end
            6'h21: begin e_rf = 1; e_sel = 8'd1; e_in = 2'd1; end
            6'h22: begin e_rf = 1; e_sel = 8'd1; e_in = 2'd3; e_rd = 1; end
            6'h24: begin e_rf = 1; e_sel = opd; e_in = 2'd2; end
            6'h19: e_clr = 3'b001;
            6'h1A: e_clr = 3'b010;
            6'h1B: e_clr = 3'b100;
            default: ;
        endcase
        if (undef) pc_tag = "R14";

        imem_data = {rsv, opc, opd};
        {flag_eq, flag_c, flag_ov, flag_z} = flg;
        acc_value = acc;
        chk(phase == 2'd0, "R2 fetch", phase, 0);
        chk(imem_addr == m_pc, "R6 pc at fetch", imem_addr, m_pc);

        @(negedge clk);
        chk(phase == 2'd1, "R2 decode", phase, 1);
        chk({dpu_en, dmem_rd_en, rf_we, dmem_we} == 4'b0, "R3 quiet decode",
            {dpu_en, dmem_rd_en, rf_we, dmem_we}, 0);
        imem_data = ~imem_data; // R3: must not disturb the captured word

        @(negedge clk);
        chk(phase == 2'd2, "R2 exec", phase, 2);
        chk(dmem_rd_en == e_rd, "R4 rd_en", dmem_rd_en, e_rd);
        if (e_rd) chk(dmem_raddr == e_ra, "R4 raddr", dmem_raddr, e_ra);
        chk(rf_we == e_rf, "R13 rf_we", rf_we, e_rf);
        if (e_rf) begin
            chk(rf_wsel == e_sel, "R13 rf_wsel", rf_wsel, e_sel);
            chk(rf_in == e_in, "R13 rf_in", rf_in, e_in);
        end
        chk(dpu_clr == e_clr, "R12 dpu_clr", dpu_clr, e_clr);
        chk(dmem_we == 1'b0, "R5 no write in exec", dmem_we, 0);
        if (opc < 6'h08) begin
            logic [3:0] e_op;
            logic [1:0] e_src;
            e_op = (opc == 6'h06 || opc < 6'h03) ? 4'd1 : 4'd2;
            e_src = (opc >= 6'h06) ? 2'd3 : ((opc % 3 == 0) ? 2'd2 : ((opc % 3 == 1) ? 2'd0 : 2'd1));
            chk(dpu_en == 1'b1, "R11 dpu_en", dpu_en, 1);
            chk(dpu_op == e_op, "R11 dpu_op", dpu_op, e_op);
            chk(dpu_src == e_src, "R11 dpu_src", dpu_src, e_src);
            if (opc == 6'h02 || opc == 6'h05) chk(dpu_data == opd, "R11 dpu_data", dpu_data, opd);
            if (opc == 6'h00 || opc == 6'h03) chk(rf_rsel == opd[2:0], "R11 rf_rsel", rf_rsel, opd[2:0]);
        end
        if (undef) chk(dpu_en == 1'b0, "R14 dpu idle", dpu_en, 0);

        @(negedge clk);
        chk(phase == 2'd3, "R2 wb", phase, 3);
        chk(dmem_we == e_wr, "R5 we", dmem_we, e_wr);
        if (e_wr) begin
            chk(dmem_waddr == e_wa, "R5/R10 waddr", dmem_waddr, e_wa);
            chk(dmem_wdata == acc, "R5 wdata", dmem_wdata, acc);
        end
        chk(dmem_rd_en == 1'b0 && rf_we == 1'b0, "R4 no read in wb", {dmem_rd_en, rf_we}, 0);
        chk(imem_addr == m_pc, "R6 pc stable", imem_addr, m_pc);

        @(negedge clk);
        m_pc = e_pc;
        m_sp = e_sp;
        chk(imem_addr == m_pc, pc_tag, imem_addr, m_pc);
    endtask

    initial begin
        rst_n = 1'b0;
        imem_data = '0;
        {flag_eq, flag_c, flag_ov, flag_z} = 4'b0;
        acc_value = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(phase == 2'd0, "R1 phase", phase, 0);
        chk(imem_addr == 8'd0, "R1 pc", imem_addr, 0);
        chk({dpu_en, dmem_rd_en, rf_we, dmem_we} == 4'b0, "R1 strobes",
            {dpu_en, dmem_rd_en, rf_we, dmem_we}, 0);
        rst_n = 1'b1;

        // R1/R10: first PUSH writes address 0, then POP wraps SP
        run_instr(2'b00, 6'h3C, 8'h55, 4'h0, 8'hA7);
        run_instr(2'b00, 6'h3D, 8'h00, 4'h0, 8'h10);
        run_instr(2'b00, 6'h3D, 8'h00, 4'h0, 8'h10);

        // Sweep every opcode under every value of the ignored bits (R14)
        for (int r = 0; r < 4; r++) begin
            for (int o = 0; o < 64; o++) begin
                run_instr(2'(r), 6'(o), 8'(o * 37 + r * 91 + 5), 4'(o ^ (r * 5)), 8'(o * 3 + r * 71));
            end
        end

        // Conditional jumps against all flag patterns (R7)
        for (int f = 0; f < 16; f++) begin
            run_instr(2'b00, 6'h14, 8'(f * 16 + 3), 4'(f), 8'h00);
            run_instr(2'b01, 6'h15, 8'(f * 16 + 5), 4'(f), 8'h00);
            run_instr(2'b10, 6'h16, 8'(f * 16 + 7), 4'(f), 8'h00);
            run_instr(2'b11, 6'h18, 8'(f * 16 + 9), 4'(f), 8'h00);
        end

        // Relative wrap and accumulator jump (R8), halt twice then step (R9)
        run_instr(2'b00, 6'h17, 8'hF0, 4'h0, 8'h00);
        run_instr(2'b00, 6'h1D, 8'h00, 4'h0, 8'hC3);
        run_instr(2'b00, 6'h3F, 8'h00, 4'hF, 8'h00);
        run_instr(2'b00, 6'h3F, 8'h00, 4'hF, 8'h00);
        run_instr(2'b00, 6'h3E, 8'h00, 4'h0, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule